// File: doc/BRIEF.md
# Boost Regulator Start-Up Sequencer

This block is the digital state machine that steps a synchronous boost regulator from power-off to regulated output. It tracks an enable input, a one-cycle millisecond tick and a set of already-digitized analog comparator flags. From these it picks the operating phase: off, a low-current linear pre-charge, a higher-current linear pre-charge, soft-start, normal boost, pass-through bypass, or fault. The analog loop, the comparators and the PWM modulator are outside this block. It drives only the select and enable lines that those circuits consume.

Each phase has its own exit rule and its own timeout. All phase timeouts are measured by one shared tick counter, which is cleared whenever the phase changes. A second counter measures how long the current limit has been continuously active. During soft-start, a reference-step strobe paces the ramp of the internal reference. A slow-ramp input divides the step rate for large output capacitors. Every fault leads to isolation and a timed restart. A registered power-good flag reports successful start-up and drops on faults, on shutdown, and on a sustained current limit.

Top module: `boost_seq_top`

## Requirements
- R1: The state code `state_o` uses 0=off, 1=linear stage 1, 2=linear stage 2, 3=soft-start, 4=boost, 5=bypass, 6=fault. While `en` is low, the block is in state 0 one clock later, from any state. In state 0, `isolate`=1 and `sw_en`=`byp_en`=`pgood`=0. The block leaves state 0 for state 1 only when `en` and `vin_uvlo_ok` are both high.
- R2: In state 1, `pre_hi`=0, `isolate`=0 and `sw_en`=0. When `vout_near_vin` is high, the next state is 3.
- R3: On the 512th tick spent in state 1 without success, the next state is 2, and there `pre_hi`=1.
- R4: In state 2, `vout_near_vin` leads to state 3. On the 1024th tick spent in state 2, the next state is 6.
- R5: In state 3, `sw_en`=1 and `ss_half_ilim`=1. With `slow_ramp` low, `ref_step` is high during every cycle in which `tick_ms` is high. `sw_en` and `byp_en` are never both high.
- R6: In state 3 with `slow_ramp` high, `ref_step` pulses only on every 4th tick: 2 pulses for 8 ticks.
- R7: In state 3, `vout_at_min` leads to state 5 if `vin_above_reg` is high, and to state 4 otherwise. On the 64th tick spent in state 3, the next state is 6.
- R8: In state 4, if `ilim_active` stays high across 2 consecutive ticks, the next state is 6. A cycle with `ilim_active` low restarts that count.
- R9: In state 5, `byp_en`=1. When `vds_over` is high, the next state is 6.
- R10: In any of states 1 to 5, `vin_uvlo_ok` low makes the next state 6.
- R11: In state 6, `isolate`=1 and `sw_en`=`byp_en`=0. On the 20th tick spent in state 6, the next state is 1.
- R12: `pgood` rises when state 3 exits to state 4 or 5. It falls when the block enters state 6 or state 0. It also falls when `ilim_active` has persisted across 64 ticks in state 4 or 5, and in that case the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| vin_uvlo_ok | input | 1 | Input above undervoltage threshold |
| vout_near_vin | input | 1 | Output within 300 mV of input |
| vout_at_min | input | 1 | Output reached minimum setpoint |
| vin_above_reg | input | 1 | Input above regulation level |
| ilim_active | input | 1 | Boost current limit active |
| vds_over | input | 1 | Bypass switch VDS over threshold |
| slow_ramp | input | 1 | Divide soft-start step rate (large output capacitance) |
| state_o | output | 3 | State code (see R1) |
| pre_hi | output | 1 | Pre-charge current high (2 A) setting |
| ss_half_ilim | output | 1 | Soft-start half current limit select |
| ref_step | output | 1 | Reference-step strobe |
| sw_en | output | 1 | Switching enable |
| byp_en | output | 1 | Bypass switch enable |
| isolate | output | 1 | Block forward and reverse current |
| pgood | output | 1 | Power-good flag |

## Verification
The assertions check, on every cycle, that a low enable forces the off state one clock later, that a low input or a VDS over-threshold in the right states lands in fault, and that soft-start completion picks bypass or boost from the input level. They also check that fault isolates and keeps power-good low, that switching and bypass never overlap, and that steps and power-good rises come only from soft-start. The timed behaviour can only be shown by the bench's scenarios: the exact tick on which each phase timeout fires, the 20-tick restart, the persistence count and its clearing, and the divided step rate.

// File: rtl/boost_seq_pkg.sv
`timescale 1ns/1ps
package boost_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_LIN1   = 3'd1,
        ST_LIN2   = 3'd2,
        ST_SOFT   = 3'd3,
        ST_BOOST  = 3'd4,
        ST_BYPASS = 3'd5,
        ST_FAULT  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic pre_hi;
        logic ss_half;
        logic sw_en;
        logic byp_en;
        logic isolate;
    } drive_t;

    typedef struct packed {
        logic lin1_to;
        logic lin2_to;
        logic ss_to;
        logic ilim_to;
        logic restart_to;
    } timeouts_t;

    function automatic drive_t decode_drive(seq_state_e s);
        drive_t d;
        d         = '0;
        d.pre_hi  = (s == ST_LIN2);
        d.ss_half = (s == ST_SOFT);
        d.sw_en   = (s == ST_SOFT) || (s == ST_BOOST);
        d.byp_en  = (s == ST_BYPASS);
        d.isolate = (s == ST_OFF) || (s == ST_FAULT);
        return d;
    endfunction

    function automatic logic is_powered(seq_state_e s);
        return (s == ST_BOOST) || (s == ST_BYPASS);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boost_seq_tickcnt.sv
`timescale 1ns/1ps
module boost_seq_tickcnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/boost_seq_ramp.sv
`timescale 1ns/1ps
module boost_seq_ramp #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic slow,
    input  logic tick,
    output logic step
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;
    logic         div_wrap;

    assign div_wrap = (div_q == LAST);
    assign step     = active && tick && (!slow || div_wrap);

    always_ff @(posedge clk) begin
        if (rst || !active || !slow) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= div_wrap ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/boost_seq_ctrl.sv
`timescale 1ns/1ps
module boost_seq_ctrl
    import boost_seq_pkg::*;
(
    input  seq_state_e cur,
    input  logic       en,
    input  logic       vin_ok,
    input  logic       near,
    input  logic       at_min,
    input  logic       above_reg,
    input  logic       vds_over,
    input  timeouts_t  to,
    output seq_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            case (cur)
                ST_OFF: begin
                    if (vin_ok) nxt = ST_LIN1;
                end
                ST_LIN1: begin
                    if (!vin_ok)        nxt = ST_FAULT;
                    else if (near)      nxt = ST_SOFT;
                    else if (to.lin1_to) nxt = ST_LIN2;
                end
                ST_LIN2: begin
                    if (!vin_ok)        nxt = ST_FAULT;
                    else if (near)      nxt = ST_SOFT;
                    else if (to.lin2_to) nxt = ST_FAULT;
                end
                ST_SOFT: begin
                    if (!vin_ok)        nxt = ST_FAULT;
                    else if (at_min)    nxt = above_reg ? ST_BYPASS : ST_BOOST;
                    else if (to.ss_to)  nxt = ST_FAULT;
                end
                ST_BOOST: begin
                    if (!vin_ok || to.ilim_to) nxt = ST_FAULT;
                end
                ST_BYPASS: begin
                    if (!vin_ok || vds_over) nxt = ST_FAULT;
                end
                ST_FAULT: begin
                    if (to.restart_to) nxt = ST_LIN1;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/boost_seq_top.sv
`timescale 1ns/1ps
module boost_seq_top
    import boost_seq_pkg::*;
#(
    parameter int LIN1_MS     = 512,
    parameter int LIN2_MS     = 1024,
    parameter int SS_MS       = 64,
    parameter int ILIM_MS     = 2,
    parameter int RESTART_MS  = 20,
    parameter int PG_ILIM_MS  = 64,
    parameter int SLOW_DIV    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick_ms,
    input  logic       vin_uvlo_ok,
    input  logic       vout_near_vin,
    input  logic       vout_at_min,
    input  logic       vin_above_reg,
    input  logic       ilim_active,
    input  logic       vds_over,
    input  logic       slow_ramp,
    output logic [2:0] state_o,
    output logic       pre_hi,
    output logic       ss_half_ilim,
    output logic       ref_step,
    output logic       sw_en,
    output logic       byp_en,
    output logic       isolate,
    output logic       pgood
);
    localparam int PHASE_MAX = max_of(max_of(LIN1_MS, LIN2_MS), max_of(SS_MS, RESTART_MS));
    localparam int PERS_MAX  = max_of(ILIM_MS, PG_ILIM_MS);
    localparam int PH_W      = $clog2(PHASE_MAX + 1);
    localparam int PS_W      = $clog2(PERS_MAX + 1);

    localparam logic [PH_W-1:0] LIN1_LAST    = PH_W'(LIN1_MS - 1);
    localparam logic [PH_W-1:0] LIN2_LAST    = PH_W'(LIN2_MS - 1);
    localparam logic [PH_W-1:0] SS_LAST      = PH_W'(SS_MS - 1);
    localparam logic [PH_W-1:0] RESTART_LAST = PH_W'(RESTART_MS - 1);
    localparam logic [PS_W-1:0] ILIM_LAST    = PS_W'(ILIM_MS - 1);
    localparam logic [PS_W-1:0] PG_LAST      = PS_W'(PG_ILIM_MS - 1);

    seq_state_e      cur_q;
    seq_state_e      nxt;
    drive_t          drv;
    timeouts_t       to;
    logic [PH_W-1:0] phase_cnt;
    logic [PS_W-1:0] pers_cnt;
    logic            pers_arm;
    logic            pg_ilim_hit;
    logic            pg_q;

    // shared phase timer, cleared on every state change
    boost_seq_tickcnt #(.W(PH_W)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .clr  (nxt != cur_q),
        .tick (tick_ms),
        .cnt  (phase_cnt)
    );

    // current-limit persistence, cleared whenever the condition drops
    assign pers_arm = ilim_active && is_powered(cur_q);

    boost_seq_tickcnt #(.W(PS_W)) u_pers (
        .clk  (clk),
        .rst  (rst),
        .clr  (!pers_arm),
        .tick (tick_ms),
        .cnt  (pers_cnt)
    );

    always_comb begin
        to            = '0;
        to.lin1_to    = tick_ms && (phase_cnt == LIN1_LAST);
        to.lin2_to    = tick_ms && (phase_cnt == LIN2_LAST);
        to.ss_to      = tick_ms && (phase_cnt == SS_LAST);
        to.restart_to = tick_ms && (phase_cnt == RESTART_LAST);
        to.ilim_to    = tick_ms && pers_arm && (cur_q == ST_BOOST) && (pers_cnt == ILIM_LAST);
    end

    assign pg_ilim_hit = tick_ms && pers_arm && (pers_cnt == PG_LAST);

    boost_seq_ctrl u_ctrl (
        .cur       (cur_q),
        .en        (en),
        .vin_ok    (vin_uvlo_ok),
        .near      (vout_near_vin),
        .at_min    (vout_at_min),
        .above_reg (vin_above_reg),
        .vds_over  (vds_over),
        .to        (to),
        .nxt       (nxt)
    );

    boost_seq_ramp #(.DIV(SLOW_DIV)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .active (cur_q == ST_SOFT),
        .slow   (slow_ramp),
        .tick   (tick_ms),
        .step   (ref_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= ST_OFF;
        end else begin
            cur_q <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q <= 1'b0;
        end else if ((nxt == ST_FAULT) || (nxt == ST_OFF)) begin
            pg_q <= 1'b0;
        end else if ((cur_q == ST_SOFT) && is_powered(nxt)) begin
            pg_q <= 1'b1;
        end else if (pg_ilim_hit) begin
            pg_q <= 1'b0;
        end
    end

    assign drv          = decode_drive(cur_q);
    assign state_o      = cur_q;
    assign pre_hi       = drv.pre_hi;
    assign ss_half_ilim = drv.ss_half;
    assign sw_en        = drv.sw_en;
    assign byp_en       = drv.byp_en;
    assign isolate      = drv.isolate;
    assign pgood        = pg_q;
endmodule

// File: rtl/boost_seq_chk.sv
`timescale 1ns/1ps
module boost_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       tick_ms,
    input logic       vin_uvlo_ok,
    input logic       vout_at_min,
    input logic       vin_above_reg,
    input logic       vds_over,
    input logic [2:0] state_o,
    input logic       pre_hi,
    input logic       ref_step,
    input logic       sw_en,
    input logic       byp_en,
    input logic       isolate,
    input logic       pgood
);
    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_o == 3'd0 && isolate && !sw_en && !byp_en && !pgood));

    assert_pre_hi_from_lin1_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pre_hi) |-> ($past(state_o) == 3'd1));

    assert_step_only_soft_R5: assert property (@(posedge clk) disable iff (rst)
        ref_step |-> (state_o == 3'd3 && tick_ms && sw_en));

    assert_no_sw_byp_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        !(sw_en && byp_en));

    assert_soft_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && en && vin_uvlo_ok && vout_at_min)
        |=> (state_o == ($past(vin_above_reg) ? 3'd5 : 3'd4)));

    assert_bypass_vds_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5 && en && vds_over) |=> (state_o == 3'd6));

    assert_uvlo_fault_R10: assert property (@(posedge clk) disable iff (rst)
        (en && !vin_uvlo_ok && state_o >= 3'd1 && state_o <= 3'd5) |=> (state_o == 3'd6));

    assert_fault_isolated_R11: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd6) |-> (isolate && !sw_en && !byp_en && !pgood));

    assert_pg_rise_from_soft_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood) |-> ($past(state_o) == 3'd3));
endmodule

bind boost_seq_top boost_seq_chk u_chk (.*);

// File: tb/sim_boost_seq_top.sv
`timescale 1ns/1ps
module sim_boost_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, tick_ms = 1'b0, vin_uvlo_ok = 1'b0, vout_near_vin = 1'b0;
    logic       vout_at_min = 1'b0, vin_above_reg = 1'b0, ilim_active = 1'b0;
    logic       vds_over = 1'b0, slow_ramp = 1'b0;
    logic [2:0] state_o;
    logic       pre_hi, ss_half_ilim, ref_step, sw_en, byp_en, isolate, pgood;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    boost_seq_top u0 (.*);

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        tick_ms = 1'b1;
        repeat (n) @(negedge clk);
        tick_ms = 1'b0;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        en = 0; tick_ms = 0; vin_uvlo_ok = 0; vout_near_vin = 0; vout_at_min = 0;
        vin_above_reg = 0; ilim_active = 0; vds_over = 0; slow_ramp = 0;
        step(2);
    endtask

    task automatic to_soft();
        go_idle();
        en = 1; vin_uvlo_ok = 1;
        step(1);
        vout_near_vin = 1;
        step(1);
    endtask

    task automatic to_powered(bit bypass);
        to_soft();
        vin_above_reg = bypass;
        vout_at_min   = 1;
        step(1);
    endtask

    task automatic t_reset();
        step(2);
        rst = 1'b0;
        step(1);
        chk("R1 reset state", state_o, 0);
        chk("R1 reset isolate", isolate, 1);
        chk("R1 reset pgood", pgood, 0);
    endtask

    task automatic t_shutdown_hold();
        go_idle();
        vin_uvlo_ok = 1;
        ticks(5);
        chk("R1 stays off with en low", state_o, 0);
        en = 1; vin_uvlo_ok = 0;
        step(1);
        chk("R1 stays off below uvlo", state_o, 0);
        vin_uvlo_ok = 1;
        step(1);
        chk("R1 enters lin1", state_o, 1);
        chk("R2 lin1 low current", pre_hi, 0);
        chk("R2 lin1 not isolated", isolate, 0);
        chk("R2 lin1 no switching", sw_en, 0);
        vout_near_vin = 1;
        step(1);
        chk("R2 lin1 to soft", state_o, 3);
    endtask

    task automatic t_lin_timeouts_restart();
        go_idle();
        en = 1; vin_uvlo_ok = 1;
        step(1);
        ticks(511);
        chk("R3 lin1 before 512", state_o, 1);
        ticks(1);
        chk("R3 lin2 after 512", state_o, 2);
        chk("R3 pre_hi in lin2", pre_hi, 1);
        ticks(1023);
        chk("R4 lin2 before 1024", state_o, 2);
        ticks(1);
        chk("R4 fault after 1024", state_o, 6);
        chk("R11 fault isolate", isolate, 1);
        chk("R11 fault no switching", sw_en, 0);
        ticks(19);
        chk("R11 fault before 20", state_o, 6);
        ticks(1);
        chk("R11 restart to lin1", state_o, 1);
    endtask

    task automatic t_lin2_success();
        go_idle();
        en = 1; vin_uvlo_ok = 1;
        step(1);
        ticks(512);
        chk("R4 at lin2", state_o, 2);
        vout_near_vin = 1;
        step(1);
        chk("R4 lin2 to soft", state_o, 3);
    endtask

    task automatic t_soft_ramp_boost();
        int n;
        to_soft();
        chk("R5 soft switching", sw_en, 1);
        chk("R5 soft half limit", ss_half_ilim, 1);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            tick_ms = 1; #1; if (ref_step) n++; @(negedge clk);
        end
        tick_ms = 0;
        chk("R5 one step per tick", n, 10);
        slow_ramp = 1;
        step(1);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            tick_ms = 1; #1; if (ref_step) n++; @(negedge clk);
        end
        tick_ms = 0;
        chk("R6 slow step count", n, 2);
        vout_at_min = 1;
        step(1);
        chk("R7 soft to boost", state_o, 4);
        chk("R12 pgood after soft", pgood, 1);
        en = 0;
        step(1);
        chk("R1 en low forces off", state_o, 0);
        chk("R12 pgood low at off", pgood, 0);
        chk("R1 isolate at off", isolate, 1);
    endtask

    task automatic t_soft_timeout();
        to_soft();
        ticks(63);
        chk("R7 soft before 64", state_o, 3);
        ticks(1);
        chk("R7 soft timeout fault", state_o, 6);
    endtask

    task automatic t_boost_ilim();
        to_powered(1'b0);
        chk("R7 boost entered", state_o, 4);
        ilim_active = 1;
        ticks(1);
        ilim_active = 0;
        step(1);
        ilim_active = 1;
        ticks(1);
        chk("R8 count cleared by drop", state_o, 4);
        ticks(1);
        chk("R8 ilim fault", state_o, 6);
        chk("R12 pgood low on fault", pgood, 0);
    endtask

    task automatic t_bypass();
        to_powered(1'b1);
        chk("R7 soft to bypass", state_o, 5);
        chk("R9 bypass enable", byp_en, 1);
        chk("R12 pgood in bypass", pgood, 1);
        ilim_active = 1;
        ticks(63);
        chk("R12 pgood before 64", pgood, 1);
        ticks(1);
        chk("R12 pgood drops at 64", pgood, 0);
        chk("R12 state kept", state_o, 5);
        ilim_active = 0;
        vds_over = 1;
        step(1);
        chk("R9 vds fault", state_o, 6);
    endtask

    task automatic t_uvlo();
        to_powered(1'b0);
        vin_uvlo_ok = 0;
        step(1);
        chk("R10 uvlo fault", state_o, 6);
    endtask

    initial begin
        t_reset();
        t_shutdown_hold();
        t_lin_timeouts_restart();
        t_lin2_success();
        t_soft_ramp_boost();
        t_soft_timeout();
        t_boost_ilim();
        t_bypass();
        t_uvlo();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule